// File: doc/BRIEF.md
# Two-Step Longest-Prefix-Match Engine

This block resolves a destination address to a next-hop identifier by longest-prefix match. It is written for scaled-down IPv4-style addresses. Routes longer than a split length live only in a small priority-ordered ternary table. Routes from a minimum length up to the split length are recorded twice. First, each length has its own existence bitmap indexed by the top address bits. Second, the next hop sits in one shared multi-way hash table. The hash key marks the prefix length with a trailing one bit: the prefix bits come first, then a single 1, then zeros.

A lookup takes two pipeline steps. In the first step every bitmap and the ternary table are probed at once, and the longest length with a set bitmap bit forms the key. In the second step one hash access returns the next hop, unless a ternary hit overrides it. One lookup may enter on every cycle. The maintenance software spreads a route shorter than the minimum length into all its covering minimum-length routes, and writes each of them.

Hash-table writes pass through a two-state commit machine, so that a write only affects lookups that enter after it. The state `HW_IDLE` means no hash write is pending. The machine moves `HW_IDLE -> HW_COMMIT` on a valid short-route write. It moves `HW_COMMIT -> HW_COMMIT` on a back-to-back write, and `HW_COMMIT -> HW_IDLE` when no further write arrives. In `HW_COMMIT` the captured key is placed in, or removed from, one way.

Top module: `lpm_engine`

## Requirements
- R1: After reset `res_valid` is 0. Every lookup then returns `res_hit`=0 with `res_nh`=`DEFAULT_NH` (8'hFF by default), because all tables start empty.
- R2: A lookup presented with `lk_valid`=1 before clock edge N produces its result, with `res_valid`=1, right after edge N+1. Lookups may be presented on consecutive cycles, and their results come out in order on consecutive cycles.
- R3: `wr_op`=2 writes ternary slot `wr_slot` with prefix `wr_pfx` (left-aligned), length `wr_len` and next hop `wr_nh`. `wr_op`=3 invalidates that slot. When several valid slots match, the lowest-numbered slot wins, whatever the lengths.
- R4: A ternary hit always overrides any short-route result.
- R5: `wr_op`=0 adds a short route with `MINL`<=`wr_len`<=`SPLIT`: it sets that length's bitmap bit and stores the next hop in the hash. A lookup uses the longest length whose bitmap bit is set.
- R6: The hash key is `SPLIT`+1 bits wide: the prefix bits, then a 1, then zeros. Routes of different lengths with equal leading bits therefore keep separate next hops.
- R7: If the ternary table misses and either no bitmap bit is set or the hash holds no entry for the formed key, the result is `res_hit`=0 with `res_nh`=`DEFAULT_NH`.
- R8: The hash has `WAYS` ways of 2^`IDXW` sets. Way 0 indexes by the top `IDXW` key bits. Way w>0 indexes by those top bits XOR (the low `IDXW` key bits >> (w-1)). An insert first updates the way that already holds the key, and otherwise fills the lowest empty way. If every way is full at its index, the insert is dropped.
- R9: A short-route write (`wr_op` 0 or 1) whose length lies outside `MINL`..`SPLIT` has no effect. A shorter route is installed by writing each of its covering `MINL`-length expansions.
- R10: A write made in the same cycle as a lookup is not seen by that lookup. It is seen by the lookup presented in the next cycle.
- R11: `wr_op`=1 removes a short route: it clears its bitmap bit and its hash entry, so lookups fall back to the next shorter route that is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | AW | Address to resolve |
| res_valid | output | 1 | Result valid, two cycles after request |
| res_hit | output | 1 | A route matched |
| res_nh | output | NHW | Next hop, or DEFAULT_NH on a miss |
| wr_en | input | 1 | Table write strobe |
| wr_op | input | 2 | 0 short add, 1 short delete, 2 long add, 3 long delete |
| wr_pfx | input | AW | Prefix, left-aligned |
| wr_len | input | $clog2(AW+1) | Prefix length |
| wr_slot | input | $clog2(TCAM_N) | Ternary slot for long routes |
| wr_nh | input | NHW | Next hop to store |

## Verification
The bench uses the defaults: 16-bit addresses, split length 10, minimum length 6, eight ternary slots, and two hash ways of 32 sets. These small widths make it cheap to pick keys whose way indices the bench can work out by hand. A route can therefore be forced into way 1, or dropped when both ways are full at its index. The /4 expansion, ternary priority against true length, and overlapping /6, /7, /8 and /10 routes all fit into a few hundred cycles.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
    typedef enum logic [1:0] {
        OP_SHORT_ADD = 2'd0,
        OP_SHORT_DEL = 2'd1,
        OP_LONG_ADD  = 2'd2,
        OP_LONG_DEL  = 2'd3
    } wr_op_t;

    typedef enum logic {
        HW_IDLE   = 1'b0,
        HW_COMMIT = 1'b1
    } hwr_state_t;
endpackage

// File: rtl/lpm_bitmaps.sv
module lpm_bitmaps #(
    parameter int AW    = 16,
    parameter int MINL  = 6,
    parameter int SPLIT = 10,
    localparam int NLEN = SPLIT - MINL + 1,
    localparam int LW   = $clog2(AW + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic            wr_set,
    input  logic [LW-1:0]   wr_len,
    input  logic [AW-1:0]   wr_pfx,
    input  logic [AW-1:0]   lk_addr,
    output logic [NLEN-1:0] hit
);
    for (genvar g = 0; g < NLEN; g++) begin : g_len
        localparam int L = MINL + g;
        logic [(1<<L)-1:0] bm_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                bm_q <= '0;
            end else if (wr_en && (wr_len == LW'(L))) begin
                bm_q[wr_pfx[AW-1 -: L]] <= wr_set;
            end
        end

        assign hit[g] = bm_q[lk_addr[AW-1 -: L]];
    end
endmodule

// File: rtl/lpm_tcam.sv
module lpm_tcam #(
    parameter int AW     = 16,
    parameter int NHW    = 8,
    parameter int TCAM_N = 8,
    localparam int LW    = $clog2(AW + 1),
    localparam int SW    = $clog2(TCAM_N)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic           wr_set,
    input  logic [SW-1:0]  wr_slot,
    input  logic [AW-1:0]  wr_pfx,
    input  logic [LW-1:0]  wr_len,
    input  logic [NHW-1:0] wr_nh,
    input  logic [AW-1:0]  lk_addr,
    output logic           hit,
    output logic [NHW-1:0] nh
);
    logic           vld_q [TCAM_N];
    logic [AW-1:0]  val_q [TCAM_N];
    logic [LW-1:0]  len_q [TCAM_N];
    logic [NHW-1:0] nh_q  [TCAM_N];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < TCAM_N; i++) vld_q[i] <= 1'b0;
        end else if (wr_en) begin
            vld_q[wr_slot] <= wr_set;
            val_q[wr_slot] <= wr_pfx;
            len_q[wr_slot] <= wr_len;
            nh_q[wr_slot]  <= wr_nh;
        end
    end

    function automatic logic slot_match(input logic [AW-1:0] a, input logic [AW-1:0] v,
                                        input logic [LW-1:0] len);
        logic ok;
        ok = 1'b1;
        for (int b = 0; b < AW; b++) begin
            if ((b >= AW - int'(len)) && (a[b] != v[b])) ok = 1'b0;
        end
        return ok;
    endfunction

    always_comb begin
        hit = 1'b0;
        nh  = '0;
        for (int i = TCAM_N - 1; i >= 0; i--) begin
            if (vld_q[i] && slot_match(lk_addr, val_q[i], len_q[i])) begin
                hit = 1'b1;
                nh  = nh_q[i];
            end
        end
    end
endmodule

// File: rtl/lpm_hash.sv
module lpm_hash
    import lpm_pkg::*;
#(
    parameter int KW   = 11,
    parameter int NHW  = 8,
    parameter int WAYS = 2,
    parameter int IDXW = 5,
    localparam int SETS = 1 << IDXW,
    localparam int WW   = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_req,
    input  logic            wr_add,
    input  logic [KW-1:0]   wr_key,
    input  logic [NHW-1:0]  wr_nh,
    input  logic [KW-1:0]   lk_key,
    output logic            hit,
    output logic [NHW-1:0]  nh,
    output logic [WAYS-1:0] way_hit
);
    logic           v_q  [WAYS][SETS];
    logic [KW-1:0]  k_q  [WAYS][SETS];
    logic [NHW-1:0] nh_q [WAYS][SETS];

    hwr_state_t     state_q;
    logic           p_add;
    logic [KW-1:0]  p_key;
    logic [NHW-1:0] p_nh;

    function automatic logic [IDXW-1:0] hidx(input logic [KW-1:0] k, input int w);
        logic [IDXW-1:0] top, low;
        top = k[KW-1 -: IDXW];
        low = k[IDXW-1:0];
        if (w == 0) return top;
        return top ^ (low >> (w - 1));
    endfunction

    // state register of the commit machine
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= HW_IDLE;
        else        state_q <= wr_req ? HW_COMMIT : HW_IDLE;
    end

    always_ff @(posedge clk) begin
        p_add <= wr_add;
        p_key <= wr_key;
        p_nh  <= wr_nh;
    end

    // way selection for the pending write
    logic            sel_valid;
    logic [WW-1:0]   sel_w;
    logic [IDXW-1:0] sel_idx;
    always_comb begin
        logic found_same, found_empty;
        found_same  = 1'b0;
        found_empty = 1'b0;
        sel_w       = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (v_q[w][hidx(p_key, w)] && k_q[w][hidx(p_key, w)] == p_key) begin
                found_same = 1'b1;
                sel_w      = WW'(w);
            end
        end
        if (!found_same && p_add) begin
            for (int w = WAYS - 1; w >= 0; w--) begin
                if (!v_q[w][hidx(p_key, w)]) begin
                    found_empty = 1'b1;
                    sel_w       = WW'(w);
                end
            end
        end
        sel_valid = found_same || found_empty;
        sel_idx   = hidx(p_key, int'(sel_w));
    end

    // output process of the commit machine
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int w = 0; w < WAYS; w++)
                for (int s = 0; s < SETS; s++) v_q[w][s] <= 1'b0;
        end else begin
            unique case (state_q)
                HW_IDLE: ;
                HW_COMMIT: begin
                    if (sel_valid) begin
                        v_q[sel_w][sel_idx]  <= p_add;
                        k_q[sel_w][sel_idx]  <= p_key;
                        nh_q[sel_w][sel_idx] <= p_nh;
                    end
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        hit = 1'b0;
        nh  = '0;
        for (int w = 0; w < WAYS; w++) begin
            way_hit[w] = v_q[w][hidx(lk_key, w)] && (k_q[w][hidx(lk_key, w)] == lk_key);
            if (way_hit[w]) begin
                hit = 1'b1;
                nh  = nh | nh_q[w][hidx(lk_key, w)];
            end
        end
    end
endmodule

// File: rtl/lpm_engine.sv
module lpm_engine
    import lpm_pkg::*;
#(
    parameter int              AW         = 16,
    parameter int              SPLIT      = 10,
    parameter int              MINL       = 6,
    parameter int              NHW        = 8,
    parameter int              TCAM_N     = 8,
    parameter int              WAYS       = 2,
    parameter int              IDXW       = 5,
    parameter logic [NHW-1:0]  DEFAULT_NH = 8'hFF
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       lk_valid,
    input  logic [AW-1:0]              lk_addr,
    output logic                       res_valid,
    output logic                       res_hit,
    output logic [NHW-1:0]             res_nh,
    input  logic                       wr_en,
    input  logic [1:0]                 wr_op,
    input  logic [AW-1:0]              wr_pfx,
    input  logic [$clog2(AW+1)-1:0]    wr_len,
    input  logic [$clog2(TCAM_N)-1:0]  wr_slot,
    input  logic [NHW-1:0]             wr_nh
);
    localparam int LW   = $clog2(AW + 1);
    localparam int KW   = SPLIT + 1;
    localparam int NLEN = SPLIT - MINL + 1;

    wr_op_t op;
    assign op = wr_op_t'(wr_op);

    logic short_wr, long_wr, wr_set;
    always_comb begin
        short_wr = 1'b0;
        long_wr  = 1'b0;
        wr_set   = 1'b0;
        unique case (op)
            OP_SHORT_ADD: begin short_wr = 1'b1; wr_set = 1'b1; end
            OP_SHORT_DEL: short_wr = 1'b1;
            OP_LONG_ADD:  begin long_wr = 1'b1; wr_set = 1'b1; end
            OP_LONG_DEL:  long_wr = 1'b1;
            default: ;
        endcase
        short_wr = short_wr && wr_en && (wr_len >= LW'(MINL)) && (wr_len <= LW'(SPLIT));
        long_wr  = long_wr && wr_en;
    end

    function automatic logic [KW-1:0] mk_key(input logic [SPLIT-1:0] pfx, input int len);
        logic [KW-1:0] k;
        int sh;
        k  = {pfx, 1'b1};
        sh = SPLIT - len;
        for (int i = 0; i < KW; i++) begin
            if (i < sh)       k[i] = 1'b0;
            else if (i == sh) k[i] = 1'b1;
        end
        return k;
    endfunction

    // step one: parallel probes
    logic [NLEN-1:0] bm_hit;
    logic            tc_hit;
    logic [NHW-1:0]  tc_nh;

    lpm_bitmaps #(.AW(AW), .MINL(MINL), .SPLIT(SPLIT)) u_bm (
        .clk(clk), .rst_n(rst_n), .wr_en(short_wr), .wr_set(wr_set),
        .wr_len(wr_len), .wr_pfx(wr_pfx), .lk_addr(lk_addr), .hit(bm_hit)
    );

    lpm_tcam #(.AW(AW), .NHW(NHW), .TCAM_N(TCAM_N)) u_tc (
        .clk(clk), .rst_n(rst_n), .wr_en(long_wr), .wr_set(wr_set),
        .wr_slot(wr_slot), .wr_pfx(wr_pfx), .wr_len(wr_len), .wr_nh(wr_nh),
        .lk_addr(lk_addr), .hit(tc_hit), .nh(tc_nh)
    );

    logic          any_short;
    logic [KW-1:0] lk_key;
    always_comb begin
        int best;
        best = MINL;
        any_short = 1'b0;
        for (int g = 0; g < NLEN; g++) begin
            if (bm_hit[g]) begin
                any_short = 1'b1;
                best      = MINL + g;
            end
        end
        lk_key = mk_key(lk_addr[AW-1 -: SPLIT], best);
    end

    logic           s1_valid, s1_short, s1_tc_hit;
    logic [KW-1:0]  s1_key;
    logic [NHW-1:0] s1_tc_nh;
    always_ff @(posedge clk) begin
        if (!rst_n) s1_valid <= 1'b0;
        else        s1_valid <= lk_valid;
        s1_short  <= any_short;
        s1_tc_hit <= tc_hit;
        s1_tc_nh  <= tc_nh;
        s1_key    <= lk_key;
    end

    // step two: single hash access
    logic            hs_hit;
    logic [NHW-1:0]  hs_nh;
    logic [WAYS-1:0] hs_way_hit;

    lpm_hash #(.KW(KW), .NHW(NHW), .WAYS(WAYS), .IDXW(IDXW)) u_hs (
        .clk(clk), .rst_n(rst_n), .wr_req(short_wr), .wr_add(wr_set),
        .wr_key(mk_key(wr_pfx[AW-1 -: SPLIT], int'(wr_len))), .wr_nh(wr_nh),
        .lk_key(s1_key), .hit(hs_hit), .nh(hs_nh), .way_hit(hs_way_hit)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_hit   <= 1'b0;
            res_nh    <= DEFAULT_NH;
        end else begin
            res_valid <= s1_valid;
            if (s1_valid && s1_tc_hit) begin
                res_hit <= 1'b1;
                res_nh  <= s1_tc_nh;
            end else if (s1_valid && s1_short && hs_hit) begin
                res_hit <= 1'b1;
                res_nh  <= hs_nh;
            end else begin
                res_hit <= 1'b0;
                res_nh  <= DEFAULT_NH;
            end
        end
    end
endmodule

// File: rtl/lpm_engine_chk.sv
module lpm_engine_chk #(
    parameter int             NHW        = 8,
    parameter int             WAYS       = 2,
    parameter logic [NHW-1:0] DEFAULT_NH = 8'hFF
) (
    input logic            clk,
    input logic            rst_n,
    input logic            lk_valid,
    input logic            res_valid,
    input logic            res_hit,
    input logic [NHW-1:0]  res_nh,
    input logic            s1_valid,
    input logic            s1_tc_hit,
    input logic [NHW-1:0]  s1_tc_nh,
    input logic [WAYS-1:0] hs_way_hit
);
    // R2
    latency_two_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |-> ##2 res_valid);

    // R2
    no_spurious_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |-> ##2 !res_valid);

    // R4
    long_override_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_valid && s1_tc_hit) |=> (res_hit && res_nh == $past(s1_tc_nh)));

    // R7
    miss_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !res_hit |-> res_nh == DEFAULT_NH);

    // R1
    hit_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_hit |-> res_valid);

    // R8
    single_way_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hs_way_hit));
endmodule

bind lpm_engine lpm_engine_chk #(.NHW(NHW), .WAYS(WAYS), .DEFAULT_NH(DEFAULT_NH)) u_chk (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .res_valid(res_valid),
    .res_hit(res_hit), .res_nh(res_nh), .s1_valid(s1_valid), .s1_tc_hit(s1_tc_hit),
    .s1_tc_nh(s1_tc_nh), .hs_way_hit(hs_way_hit)
);

// File: tb/sim_lpm_engine.sv
module sim_lpm_engine;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0;
    logic [15:0] lk_addr = '0;
    logic        res_valid, res_hit;
    logic [7:0]  res_nh;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_op = '0;
    logic [15:0] wr_pfx = '0;
    logic [4:0]  wr_len = '0;
    logic [2:0]  wr_slot = '0;
    logic [7:0]  wr_nh = '0;

    int nvec = 0;
    int nbad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lpm_engine u0 (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_addr(lk_addr),
        .res_valid(res_valid), .res_hit(res_hit), .res_nh(res_nh),
        .wr_en(wr_en), .wr_op(wr_op), .wr_pfx(wr_pfx), .wr_len(wr_len),
        .wr_slot(wr_slot), .wr_nh(wr_nh)
    );

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    endtask

    task automatic check_res(string req, logic ev, logic eh, logic [7:0] en);
        nvec++;
        if (res_valid !== ev || (ev && (res_hit !== eh || res_nh !== en))) begin
            nbad++;
            $display("FAIL %s: got v=%0b hit=%0b nh=%02h expected v=%0b hit=%0b nh=%02h",
                     req, res_valid, res_hit, res_nh, ev, eh, en);
        end
    endtask

    // entered right after a negedge, leaves right after a negedge
    task automatic do_wr(logic [1:0] op, logic [15:0] pfx, int len, int slot, logic [7:0] nh);
        wr_en = 1'b1; wr_op = op; wr_pfx = pfx; wr_len = 5'(len);
        wr_slot = 3'(slot); wr_nh = nh;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic lookup(logic [15:0] a, logic eh, logic [7:0] en, string req);
        lk_valid = 1'b1; lk_addr = a;
        @(negedge clk);
        lk_valid = 1'b0;
        @(negedge clk);
        check_res(req, 1'b1, eh, en);
    endtask

    task automatic t_reset();
        check_res("R1 idle", 1'b0, 1'b0, 8'hFF);
        lookup(16'h1234, 1'b0, 8'hFF, "R1 empty");
        lookup(16'hB300, 1'b0, 8'hFF, "R1 empty");
    endtask

    task automatic t_long();
        do_wr(2'd2, 16'h1234, 14, 0, 8'h22);
        do_wr(2'd2, 16'h1230, 12, 1, 8'h21);
        do_wr(2'd2, 16'h1235, 16, 2, 8'h23);
        lookup(16'h1235, 1'b1, 8'h22, "R3 lowest slot wins");
        lookup(16'h1239, 1'b1, 8'h21, "R3 /12 slot");
        lookup(16'h1240, 1'b0, 8'hFF, "R7 no match");
    endtask

    task automatic t_short();
        do_wr(2'd0, 16'h1000, 6, 0, 8'h31);
        do_wr(2'd0, 16'h1300, 8, 0, 8'h32);
        do_wr(2'd0, 16'h13C0, 10, 0, 8'h33);
        lookup(16'h1236, 1'b1, 8'h22, "R4 long overrides short");
        lookup(16'h12FF, 1'b1, 8'h31, "R5 /6");
        lookup(16'h13AB, 1'b1, 8'h32, "R5 /8 longest");
        lookup(16'h13C5, 1'b1, 8'h33, "R5 /10 longest");
    endtask

    task automatic t_ways();
        do_wr(2'd0, 16'hB000, 6, 0, 8'h41);
        do_wr(2'd0, 16'hB400, 6, 0, 8'h42);
        do_wr(2'd0, 16'hB200, 7, 0, 8'h43);
        do_wr(2'd0, 16'hB600, 7, 0, 8'h44);
        lookup(16'hB0AA, 1'b1, 8'h41, "R8 way0");
        lookup(16'hB4AA, 1'b1, 8'h42, "R8 way1");
        lookup(16'hB355, 1'b1, 8'h43, "R6 /7 key distinct from /6");
        lookup(16'hB700, 1'b0, 8'hFF, "R8 dropped insert R7");
    endtask

    task automatic t_ignore_expand();
        do_wr(2'd0, 16'h8000, 4, 0, 8'h55);
        do_wr(2'd0, 16'h9000, 11, 0, 8'h56);
        lookup(16'h8123, 1'b0, 8'hFF, "R9 short len below min ignored");
        lookup(16'h9000, 1'b0, 8'hFF, "R9 short len above split ignored");
        for (int i = 0; i < 4; i++) do_wr(2'd0, 16'hC000 | 16'(i << 10), 6, 0, 8'h66);
        lookup(16'hC123, 1'b1, 8'h66, "R9 expansion low");
        lookup(16'hCF00, 1'b1, 8'h66, "R9 expansion high");
        lookup(16'hD000, 1'b0, 8'hFF, "R9 outside expansion");
    endtask

    task automatic t_same_cycle();
        wr_en = 1'b1; wr_op = 2'd0; wr_pfx = 16'h5500; wr_len = 5'd8; wr_nh = 8'h77;
        lk_valid = 1'b1; lk_addr = 16'h5512;
        @(negedge clk);
        wr_en = 1'b0;
        lk_valid = 1'b1; lk_addr = 16'h5512;
        @(negedge clk);
        lk_valid = 1'b0;
        check_res("R10 same-cycle write unseen", 1'b1, 1'b0, 8'hFF);
        @(negedge clk);
        check_res("R10 next lookup sees write", 1'b1, 1'b1, 8'h77);
    endtask

    task automatic t_stream();
        lk_valid = 1'b1; lk_addr = 16'h12FF;
        @(negedge clk);
        lk_addr = 16'h13AB;
        @(negedge clk);
        lk_addr = 16'hB355;
        check_res("R2 stream 1", 1'b1, 1'b1, 8'h31);
        @(negedge clk);
        lk_valid = 1'b0;
        check_res("R2 stream 2", 1'b1, 1'b1, 8'h32);
        @(negedge clk);
        check_res("R2 stream 3", 1'b1, 1'b1, 8'h43);
        @(negedge clk);
        check_res("R2 idle after stream", 1'b0, 1'b0, 8'hFF);
    endtask

    task automatic t_delete();
        do_wr(2'd1, 16'h13C0, 10, 0, 8'h00);
        lookup(16'h13C5, 1'b1, 8'h32, "R11 falls back to /8");
        do_wr(2'd3, 16'h0000, 0, 0, 8'h00);
        lookup(16'h1235, 1'b1, 8'h21, "R3 R11 slot removed");
        do_wr(2'd3, 16'h0000, 0, 1, 8'h00);
        lookup(16'h1239, 1'b1, 8'h31, "R11 long gone, short /6");
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        nbad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_long();
        t_short();
        t_ways();
        t_ignore_expand();
        t_same_cycle();
        t_stream();
        t_delete();
        finish_run();
    end
endmodule